// File: doc/BRIEF.md
# Three-Stage Pipeline Forwarding Control

This block resolves read-after-write hazards in a 32-bit in-order RISC-V pipeline with three stages: decode with register read, execute with branch resolution, and writeback. Each cycle it takes the source register indices of the instruction in decode, along with that instruction's destination index, write enable and writeback source. It tracks the two older instructions still in flight and drives the operand multiplexer selects for both the decode and the execute stages.

The writeback-stage result is the only value ever forwarded. It goes to one of two places, depending on how far apart the producer and the consumer are. When the producer is two instructions older, the result is steered into the decode-stage operand latch. When the producer is the immediately preceding instruction, the result is steered into the execute-stage operands in the following cycle. A producer that is a memory load and sits directly ahead of its consumer is not forwarded into execute. Instead, the block requests a one-cycle bubble and a program-counter hold. After the bubble, the load is two positions ahead, and its data takes the decode-stage path. An external stall, such as a cache miss, freezes all tracking state.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, every select is 0, wbSrcSel is 0, and insertBubble and holdPc are 0.
- R2: fwdDecSel[i] is 1 in any cycle where the instruction in writeback has its write enable set, writes a nonzero index equal to source i in decode, and source i is marked used.
- R3: fwdExSel[i] is 1 in the cycle after a decode instruction advances, if at advance time source i matched the enabled, nonzero destination of the instruction then in execute. Such a producer is never a load.
- R4: A destination of index 0, or a destination whose write enable is 0, never causes a forward or a bubble.
- R5: When both older instructions write the same source register, the execute-stage select is asserted in the following cycle. The younger producer's value therefore replaces the one latched in decode.
- R6: When a used source of the decode instruction matches the enabled, nonzero destination of the instruction in execute, and that instruction's writeback source is memory (code 1), holdPc is 1. In the same cycle, insertBubble is 1 unless extStall is 1. The execute stage is empty in the next cycle.
- R7: After a load bubble, a consumer held in decode receives the load result through fwdDecSel.
- R8: wbSrcSel gives the writeback source code of the instruction in writeback: 0 for ALU result, 1 for memory data, 2 for PC+4. It is 0 when writeback holds a bubble.
- R9: While extStall is 1, no stage record moves and insertBubble is 0. holdPc still reports a pending load hazard.
- R10: A source whose use flag is 0 never forwards and never causes a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extStall | input | 1 | Freeze from outside, e.g. cache miss |
| decSrcIdx | input | NUM_SRC*IDX_W | Source register indices of the decode instruction, source i at bits [i*IDX_W +: IDX_W] |
| decSrcUse | input | NUM_SRC | Per-source flag: the instruction reads this source |
| decRd | input | IDX_W | Destination index of the decode instruction |
| decWe | input | 1 | Decode instruction writes a register |
| decWbSrc | input | 2 | Writeback source code of the decode instruction (0 ALU, 1 memory, 2 PC+4) |
| fwdDecSel | output | NUM_SRC | Per source: take the writeback result into decode instead of the register file |
| fwdExSel | output | NUM_SRC | Per source: take the writeback result into execute instead of the latched operand |
| wbSrcSel | output | 2 | Writeback-data mux select for the instruction in writeback |
| insertBubble | output | 1 | Put a no-op into execute this cycle |
| holdPc | output | 1 | Hold the program counter and the decode instruction |

## Verification
The bench builds the block with its defaults: five-bit register indices and two sources per instruction. Random stimulus draws destinations and sources from registers 0 to 3 only. This makes distance-one and distance-two collisions, double matches on one register, and matches on register 0 frequent, so each forwarding path and its exclusions comes up many times. Loads are mixed with external stalls. This also reaches the cases where a load hazard arrives during a stall, or a stall lands on a bubble cycle.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wbSrcE;

  typedef struct packed {
    logic advance;  // stage records move forward at this edge
    logic bubble;   // execute receives an empty record instead of decode
  } ctrlStrobeT;

endpackage

// File: rtl/fhc_match.sv
module fhc_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] srcIdx,
  input  logic             srcUse,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic             dstWe,
  output logic             hit
);
  // Register zero is never a real producer.
  assign hit = srcUse && dstWe && (dstIdx != '0) && (dstIdx == srcIdx);
endmodule

// File: rtl/fhc_path.sv
module fhc_path
  import fhc_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strobe,
  input  logic [NUM_SRC*IDX_W-1:0] decSrcIdx,
  input  logic [NUM_SRC-1:0]       decSrcUse,
  input  logic [IDX_W-1:0]         decRd,
  input  logic                     decWe,
  input  wbSrcE                    decWbSrc,
  output logic [NUM_SRC-1:0]       fwdDecSel,
  output logic [NUM_SRC-1:0]       fwdExSel,
  output logic [1:0]               wbSrcSel,
  output logic [NUM_SRC-1:0]       loadMatch
);

  // Execute-stage record (instruction one ahead of decode)
  logic [IDX_W-1:0]   exRd;
  logic               exWe;
  wbSrcE              exSrc;
  logic [NUM_SRC-1:0] exFwd;
  // Writeback-stage record (instruction two ahead of decode)
  logic [IDX_W-1:0]   wbRd;
  logic               wbWe;
  wbSrcE              wbSrc;

  logic [NUM_SRC-1:0] exHit;
  logic [NUM_SRC-1:0] wbHit;
  logic               exIsLoad;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    fhc_match #(.IDX_W(IDX_W)) uExCmp (
      .srcIdx(decSrcIdx[g*IDX_W +: IDX_W]),
      .srcUse(decSrcUse[g]),
      .dstIdx(exRd),
      .dstWe (exWe),
      .hit   (exHit[g])
    );
    fhc_match #(.IDX_W(IDX_W)) uWbCmp (
      .srcIdx(decSrcIdx[g*IDX_W +: IDX_W]),
      .srcUse(decSrcUse[g]),
      .dstIdx(wbRd),
      .dstWe (wbWe),
      .hit   (wbHit[g])
    );
  end

  assign exIsLoad  = (exSrc == WB_MEM);
  assign loadMatch = exHit & {NUM_SRC{exIsLoad}};
  assign fwdDecSel = wbHit;
  assign fwdExSel  = exFwd;
  assign wbSrcSel  = wbSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exRd  <= '0;
      exWe  <= 1'b0;
      exSrc <= WB_ALU;
      exFwd <= '0;
      wbRd  <= '0;
      wbWe  <= 1'b0;
      wbSrc <= WB_ALU;
    end else if (strobe.advance) begin
      wbRd  <= exRd;
      wbWe  <= exWe;
      wbSrc <= exSrc;
      if (strobe.bubble) begin
        exRd  <= '0;
        exWe  <= 1'b0;
        exSrc <= WB_ALU;
        exFwd <= '0;
      end else begin
        exRd  <= decRd;
        exWe  <= decWe;
        exSrc <= decWbSrc;
        // Producer directly ahead will sit in writeback next cycle.
        exFwd <= exHit;
      end
    end
  end

endmodule

// File: rtl/fhc_ctrl.sv
module fhc_ctrl
  import fhc_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] loadMatch,
  input  logic               extStall,
  output ctrlStrobeT         strobe,
  output logic               insertBubble,
  output logic               holdPc
);
  logic loadHazard;

  assign loadHazard     = |loadMatch;
  assign strobe.advance = ~extStall;
  assign strobe.bubble  = loadHazard;
  assign insertBubble   = loadHazard & ~extStall;
  assign holdPc         = loadHazard;
endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
  import fhc_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extStall,
  input  logic [NUM_SRC*IDX_W-1:0] decSrcIdx,
  input  logic [NUM_SRC-1:0]       decSrcUse,
  input  logic [IDX_W-1:0]         decRd,
  input  logic                     decWe,
  input  logic [1:0]               decWbSrc,
  output logic [NUM_SRC-1:0]       fwdDecSel,
  output logic [NUM_SRC-1:0]       fwdExSel,
  output logic [1:0]               wbSrcSel,
  output logic                     insertBubble,
  output logic                     holdPc
);
  ctrlStrobeT         strobe;
  logic [NUM_SRC-1:0] loadMatch;

  fhc_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .loadMatch   (loadMatch),
    .extStall    (extStall),
    .strobe      (strobe),
    .insertBubble(insertBubble),
    .holdPc      (holdPc)
  );

  fhc_path #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .decSrcIdx(decSrcIdx),
    .decSrcUse(decSrcUse),
    .decRd    (decRd),
    .decWe    (decWe),
    .decWbSrc (wbSrcE'(decWbSrc)),
    .fwdDecSel(fwdDecSel),
    .fwdExSel (fwdExSel),
    .wbSrcSel (wbSrcSel),
    .loadMatch(loadMatch)
  );
endmodule

// File: rtl/fwd_hazard_ctrl_chk.sv
module fwd_hazard_ctrl_chk #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     extStall,
  input logic [NUM_SRC*IDX_W-1:0] decSrcIdx,
  input logic [NUM_SRC-1:0]       decSrcUse,
  input logic [NUM_SRC-1:0]       fwdDecSel,
  input logic [NUM_SRC-1:0]       fwdExSel,
  input logic [1:0]               wbSrcSel,
  input logic                     insertBubble,
  input logic                     holdPc
);

  assert_bubble_holds_pc_R6: assert property (@(posedge clk) disable iff (!rstN)
    insertBubble |-> holdPc);

  assert_bubble_empties_ex_R6: assert property (@(posedge clk) disable iff (!rstN)
    insertBubble |=> (fwdExSel == '0) && !holdPc);

  assert_bubble_load_reaches_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    insertBubble |=> (wbSrcSel == 2'd1));

  assert_no_bubble_in_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    extStall |-> !insertBubble);

  assert_stall_freezes_R9: assert property (@(posedge clk) disable iff (!rstN)
    extStall |=> $stable(fwdExSel) && $stable(wbSrcSel));

  assert_wb_code_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbSrcSel != 2'd3);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrcChk
    assert_dec_fwd_needs_src_R4: assert property (@(posedge clk) disable iff (!rstN)
      fwdDecSel[g] |-> decSrcUse[g] && (decSrcIdx[g*IDX_W +: IDX_W] != '0));
  end

endmodule

bind fwd_hazard_ctrl fwd_hazard_ctrl_chk #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .extStall    (extStall),
  .decSrcIdx   (decSrcIdx),
  .decSrcUse   (decSrcUse),
  .fwdDecSel   (fwdDecSel),
  .fwdExSel    (fwdExSel),
  .wbSrcSel    (wbSrcSel),
  .insertBubble(insertBubble),
  .holdPc      (holdPc)
);

// File: tb/fwd_hazard_ctrl_tb.sv
module fwd_hazard_ctrl_tb;
  localparam int IDX_W = 5;
  localparam int NSRC  = 2;
  localparam int ALU = 0, MEM = 1, LNK = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extStall = 1'b0;
  logic [NSRC*IDX_W-1:0] decSrcIdx = '0;
  logic [NSRC-1:0] decSrcUse = '0;
  logic [IDX_W-1:0] decRd = '0;
  logic decWe = 1'b0;
  logic [1:0] decWbSrc = '0;
  logic [NSRC-1:0] fwdDecSel, fwdExSel;
  logic [1:0] wbSrcSel;
  logic insertBubble, holdPc;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  fwd_hazard_ctrl #(.IDX_W(IDX_W), .NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rstN(rstN), .extStall(extStall),
    .decSrcIdx(decSrcIdx), .decSrcUse(decSrcUse), .decRd(decRd),
    .decWe(decWe), .decWbSrc(decWbSrc),
    .fwdDecSel(fwdDecSel), .fwdExSel(fwdExSel), .wbSrcSel(wbSrcSel),
    .insertBubble(insertBubble), .holdPc(holdPc)
  );

  // Behavioural model: queue of in-flight instructions, [0] one ahead, [1] two ahead.
  typedef struct {
    int rd;
    bit we;
    int src;
    bit [NSRC-1:0] fwd;
  } instT;
  instT flight[$];

  function automatic instT emptyInst();
    instT e;
    e.rd = 0; e.we = 0; e.src = ALU; e.fwd = '0;
    return e;
  endfunction

  function automatic bit writes(instT p, int r, bit u);
    return u && p.we && p.rd != 0 && p.rd == r;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  bit lastHold = 0;

  task automatic step(int s0, bit u0, int s1, bit u1, int rd, bit we, int src, bit stall);
    bit [NSRC-1:0] eDec, hitEx;
    bit hazard;
    int srcs[NSRC];
    bit uses[NSRC];
    instT nxt;
    srcs[0] = s0; srcs[1] = s1; uses[0] = u0; uses[1] = u1;
    @(negedge clk);
    decSrcIdx = {IDX_W'(s1), IDX_W'(s0)};
    decSrcUse = {u1, u0};
    decRd = IDX_W'(rd); decWe = we; decWbSrc = 2'(src); extStall = stall;
    hazard = 0;
    for (int i = 0; i < NSRC; i++) begin
      hitEx[i] = writes(flight[0], srcs[i], uses[i]);
      eDec[i]  = writes(flight[1], srcs[i], uses[i]);
      if (hitEx[i] && flight[0].src == MEM) hazard = 1;
    end
    #4;
    check("R2,R4,R7,R10 fwdDecSel", int'(fwdDecSel), int'(eDec));
    check("R3,R5 fwdExSel", int'(fwdExSel), int'(flight[0].fwd));
    check("R8 wbSrcSel", int'(wbSrcSel), flight[1].src);
    check("R6,R9,R10 insertBubble", int'(insertBubble), int'(hazard && !stall));
    check("R6,R9 holdPc", int'(holdPc), int'(hazard));
    lastHold = hazard;
    @(posedge clk);
    if (!stall) begin
      if (hazard) nxt = emptyInst();
      else begin
        nxt.rd = rd; nxt.we = we; nxt.src = src; nxt.fwd = hitEx;
      end
      void'(flight.pop_back());
      flight.push_front(nxt);
    end
  endtask

  task automatic nop(bit stall = 0);
    step(0, 0, 0, 0, 0, 0, ALU, stall);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    flight.push_back(emptyInst());
    flight.push_back(emptyInst());
    repeat (3) @(negedge clk);
    #4;
    // R1: reset state
    check("R1 reset fwdDecSel", int'(fwdDecSel), 0);
    check("R1 reset fwdExSel", int'(fwdExSel), 0);
    check("R1 reset wbSrcSel", int'(wbSrcSel), 0);
    check("R1 reset bubble/hold", int'({insertBubble, holdPc}), 0);
    @(negedge clk);
    rstN = 1'b1;
    nop();  // first cycle after reset: model expects all zero (R1)

    // R2: distance-two forward into decode
    step(0, 0, 0, 0, 1, 1, ALU, 0);
    nop();
    step(1, 1, 0, 0, 0, 0, ALU, 0);
    // R3: distance-one forward into execute
    step(0, 0, 0, 0, 2, 1, ALU, 0);
    step(0, 0, 2, 1, 0, 0, ALU, 0);
    nop(); nop();
    // R4: register zero and disabled writes are ignored
    step(0, 0, 0, 0, 0, 1, MEM, 0);
    step(0, 1, 0, 1, 0, 0, ALU, 0);
    step(0, 1, 0, 1, 0, 0, ALU, 0);
    step(0, 0, 0, 0, 5, 0, MEM, 0);
    step(5, 1, 5, 1, 0, 0, ALU, 0);
    step(5, 1, 5, 1, 0, 0, ALU, 0);
    // R5: both older instructions write x6
    step(0, 0, 0, 0, 6, 1, ALU, 0);
    step(0, 0, 0, 0, 6, 1, ALU, 0);
    step(6, 1, 6, 1, 0, 0, ALU, 0);
    nop();
    // R6, R7: load-use bubble then decode forward
    step(0, 0, 0, 0, 7, 1, MEM, 0);
    step(7, 1, 0, 0, 3, 1, ALU, 0);
    step(7, 1, 0, 0, 3, 1, ALU, 0);
    nop(); nop();
    // R9: load hazard under stall
    step(0, 0, 0, 0, 8, 1, MEM, 0);
    step(0, 0, 8, 1, 0, 0, ALU, 1);
    step(0, 0, 8, 1, 0, 0, ALU, 1);
    step(0, 0, 8, 1, 0, 0, ALU, 0);
    step(0, 0, 8, 1, 0, 0, ALU, 0);
    // R8: link result in writeback
    step(0, 0, 0, 0, 9, 1, LNK, 0);
    nop(); nop();
    // R10: unused sources
    step(0, 0, 0, 0, 4, 1, MEM, 0);
    step(4, 0, 4, 0, 0, 0, ALU, 0);
    step(4, 0, 4, 0, 0, 0, ALU, 0);
    nop(); nop();

    // Mixed traffic: small register range for frequent collisions
    begin
      int s0 = 0, s1 = 0, rd = 0, src = 0;
      bit u0 = 0, u1 = 0, we = 0;
      for (int n = 0; n < 1500; n++) begin
        bit st;
        if (!lastHold) begin
          s0 = $urandom_range(0, 3); s1 = $urandom_range(0, 3);
          u0 = $urandom_range(0, 3) != 0; u1 = $urandom_range(0, 2) != 0;
          rd = $urandom_range(0, 3); we = $urandom_range(0, 4) != 0;
          src = $urandom_range(0, 2);
        end
        st = $urandom_range(0, 9) == 0;
        step(s0, u0, s1, u1, rd, we, src, st);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule